// File: doc/BRIEF.md
# Redundant Thread Store Comparator

Two redundant copies of a program run as a leading thread and a trailing thread. Neither copy may change state outside the protected region on its own. Each thread hands this block its committed stores, as address and data, and the addresses of its uncached loads. Each thread writes into its own queue. Cached loads never enter the queues.

The comparator takes the oldest entry of each queue as a pair. It decides on a pair only when both queue heads hold an entry. The two threads may therefore reach the same operation many cycles apart.

- A store pair whose kind, address and data all agree is offered once to the data-cache port over a valid/ready handshake.
- An uncached-load pair whose addresses agree is retired silently.
- Any disagreement sets a sticky fault flag and discards the offending pair. While the flag is set, nothing is retired or released. The flag stays set until an explicit clear.

Top module: `redundant_store_cmp`

## Requirements
- R1: During and right after reset, `fault` and `mem_valid` are 0, and both `lead_ready` and `trail_ready` are 1.
- R2: When both queue heads are stores (kind code 0) with equal address and equal data, `mem_valid` is 1 and carries that address and data. This holds however many cycles apart the two entries were pushed.
- R3: While `mem_valid` is 1 and `mem_ready` is 0, the pair stays at the heads, and `mem_valid`, `mem_addr` and `mem_data` stay unchanged. Each validated store completes the handshake exactly once.
- R4: When both heads are uncached loads (kind code 1) with equal addresses, the pair is retired in one cycle with no release and no fault. Their data fields are ignored.
- R5: A store pair whose addresses or whose data differ sets `fault` on the next clock edge and is never released.
- R6: An uncached-load pair whose addresses differ sets `fault` on the next clock edge.
- R7: A pair whose kind codes differ sets `fault` on the next clock edge.
- R8: `fault` stays 1 until a cycle with `fault_clr` high. The pair that caused the fault is discarded. While `fault` is 1, `mem_valid` is 0 and no entry leaves either queue. Pairs queued behind the fault are handled normally once the flag drops.
- R9: Each queue holds DEPTH entries (16 by default). When a queue is full its ready output is 0, and a push into it is ignored.
- R10: Pairs are taken in the order each thread pushed its entries, so releases appear in program order.
- R11: `mem_valid` is 0 whenever either queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lead_push | input | 1 | Leading thread pushes an entry |
| lead_kind | input | 1 | Leading entry kind: 0 store, 1 uncached load |
| lead_addr | input | ADDR_W | Leading entry address |
| lead_data | input | DATA_W | Leading entry store data |
| lead_ready | output | 1 | Leading queue has space |
| trail_push | input | 1 | Trailing thread pushes an entry |
| trail_kind | input | 1 | Trailing entry kind: 0 store, 1 uncached load |
| trail_addr | input | ADDR_W | Trailing entry address |
| trail_data | input | DATA_W | Trailing entry store data |
| trail_ready | output | 1 | Trailing queue has space |
| mem_valid | output | 1 | Validated store offered to the data cache |
| mem_ready | input | 1 | Data cache accepts the offered store |
| mem_addr | output | ADDR_W | Released store address |
| mem_data | output | DATA_W | Released store data |
| fault | output | 1 | Sticky mismatch flag |
| fault_clr | input | 1 | Clears the fault flag |

## Verification
Each pushed entry becomes a queue head one clock edge after the push. A matched store therefore shows on `mem_valid` in the cycle after the later of its two pushes. It leaves on the first edge at which `mem_ready` is high. Verdicts on mismatches are registered, so `fault` rises one edge after both heads are present. After a clear, a waiting pair is released one edge later. The bench drives and samples on falling edges and waits at least these counts before each check. Releases are logged at rising edges and compared in order with values the bench computes from loop indices.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic {
        KIND_STORE  = 1'b0,
        KIND_UCLOAD = 1'b1
    } kind_e;

    typedef enum logic [1:0] {
        VERD_RETIRE  = 2'd0,
        VERD_RELEASE = 2'd1,
        VERD_FAULT   = 2'd2
    } verdict_e;

    // Decide what to do with a pair of heads from the comparison results.
    function automatic verdict_e judge(input kind_e k_lead, input kind_e k_trail,
                                       input logic addr_eq, input logic data_eq);
        verdict_e v;
        if (k_lead != k_trail)       v = VERD_FAULT;
        else if (!addr_eq)           v = VERD_FAULT;
        else if (k_lead == KIND_STORE)
            v = data_eq ? VERD_RELEASE : VERD_FAULT;
        else                         v = VERD_RETIRE;
        return v;
    endfunction

endpackage

// File: rtl/rsc_queue.sv
module rsc_queue #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_word,
    output logic             in_ready,
    input  logic             pop,
    output logic             head_valid,
    output logic [WIDTH-1:0] head_word
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [WIDTH-1:0] store_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign in_ready   = (count != FULL);
    assign head_valid = (count != '0);
    assign head_word  = store_q[rd_ptr];
    assign do_push    = push && in_ready;
    assign do_pop     = pop && head_valid;

    always_ff @(posedge clk) begin
        if (do_push) store_q[wr_ptr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rsc_pair_judge.sv
module rsc_pair_judge
    import rsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  kind_e              lead_kind,
    input  kind_e              trail_kind,
    input  logic [ADDR_W-1:0]  lead_addr,
    input  logic [ADDR_W-1:0]  trail_addr,
    input  logic [DATA_W-1:0]  lead_data,
    input  logic [DATA_W-1:0]  trail_data,
    output verdict_e           verdict
);
    logic addr_eq, data_eq;

    assign addr_eq = (lead_addr == trail_addr);
    assign data_eq = (lead_data == trail_data);
    assign verdict = judge(lead_kind, trail_kind, addr_eq, data_eq);

endmodule

// File: rtl/rsc_release_ctl.sv
module rsc_release_ctl
    import rsc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     both_valid,
    input  verdict_e verdict,
    input  logic     mem_ready,
    input  logic     fault_clr,
    output logic     mem_valid,
    output logic     pop_pair,
    output logic     fault
);
    logic fault_q;
    logic active;

    assign active    = both_valid && !fault_q;
    assign mem_valid = active && (verdict == VERD_RELEASE);
    assign pop_pair  = active && ((verdict == VERD_RETIRE) ||
                                  (verdict == VERD_FAULT)  ||
                                  (verdict == VERD_RELEASE && mem_ready));
    assign fault     = fault_q;

    always_ff @(posedge clk) begin
        if (rst)                                  fault_q <= 1'b0;
        else if (active && verdict == VERD_FAULT) fault_q <= 1'b1;
        else if (fault_clr)                       fault_q <= 1'b0;
    end

endmodule

// File: rtl/redundant_store_cmp.sv
module redundant_store_cmp
    import rsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lead_push,
    input  logic              lead_kind,
    input  logic [ADDR_W-1:0] lead_addr,
    input  logic [DATA_W-1:0] lead_data,
    output logic              lead_ready,
    input  logic              trail_push,
    input  logic              trail_kind,
    input  logic [ADDR_W-1:0] trail_addr,
    input  logic [DATA_W-1:0] trail_data,
    output logic              trail_ready,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              fault,
    input  logic              fault_clr
);
    localparam int EW = 1 + ADDR_W + DATA_W;

    logic [1:0]    push_v, in_rdy, head_v;
    logic [EW-1:0] push_w [2];
    logic [EW-1:0] head_w [2];
    logic          pop_pair;
    verdict_e      verdict;

    kind_e             lead_h_kind, trail_h_kind;
    logic [ADDR_W-1:0] lead_h_addr, trail_h_addr;
    logic [DATA_W-1:0] lead_h_data, trail_h_data;

    assign push_v    = {trail_push, lead_push};
    assign push_w[0] = {lead_kind, lead_addr, lead_data};
    assign push_w[1] = {trail_kind, trail_addr, trail_data};

    // Index 0 is the leading thread, index 1 the trailing thread.
    for (genvar t = 0; t < 2; t++) begin : g_thread
        rsc_queue #(.WIDTH(EW), .DEPTH(DEPTH)) u_queue (
            .clk        (clk),
            .rst        (rst),
            .push       (push_v[t]),
            .push_word  (push_w[t]),
            .in_ready   (in_rdy[t]),
            .pop        (pop_pair),
            .head_valid (head_v[t]),
            .head_word  (head_w[t])
        );
    end

    assign lead_ready  = in_rdy[0];
    assign trail_ready = in_rdy[1];

    assign lead_h_kind  = kind_e'(head_w[0][EW-1]);
    assign lead_h_addr  = head_w[0][ADDR_W+DATA_W-1:DATA_W];
    assign lead_h_data  = head_w[0][DATA_W-1:0];
    assign trail_h_kind = kind_e'(head_w[1][EW-1]);
    assign trail_h_addr = head_w[1][ADDR_W+DATA_W-1:DATA_W];
    assign trail_h_data = head_w[1][DATA_W-1:0];

    rsc_pair_judge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_judge (
        .lead_kind  (lead_h_kind),
        .trail_kind (trail_h_kind),
        .lead_addr  (lead_h_addr),
        .trail_addr (trail_h_addr),
        .lead_data  (lead_h_data),
        .trail_data (trail_h_data),
        .verdict    (verdict)
    );

    rsc_release_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .both_valid (&head_v),
        .verdict    (verdict),
        .mem_ready  (mem_ready),
        .fault_clr  (fault_clr),
        .mem_valid  (mem_valid),
        .pop_pair   (pop_pair),
        .fault      (fault)
    );

    assign mem_addr = lead_h_addr;
    assign mem_data = lead_h_data;

endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              fault,
    input logic              fault_clr,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic              lead_ready,
    input logic              trail_ready,
    input logic [1:0]        head_v,
    input logic              lead_k,
    input logic              trail_k
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!fault && !mem_valid && lead_ready && trail_ready));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R8
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (fault && !fault_clr) |=> fault);

    // R8
    no_release_in_fault_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> !mem_valid);

    // R7
    kind_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (head_v == 2'b11 && !fault && lead_k != trail_k) |=> fault);

    // R11
    one_head_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (head_v != 2'b11) |-> !mem_valid);

endmodule

bind redundant_store_cmp rsc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fault       (fault),
    .fault_clr   (fault_clr),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data),
    .lead_ready  (lead_ready),
    .trail_ready (trail_ready),
    .head_v      (head_v),
    .lead_k      (head_w[0][1+ADDR_W+DATA_W-1]),
    .trail_k     (head_w[1][1+ADDR_W+DATA_W-1])
);

// File: tb/redundant_store_cmp_test.sv
module redundant_store_cmp_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int QD = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lead_push = 1'b0, trail_push = 1'b0;
    logic          lead_kind = 1'b0, trail_kind = 1'b0;
    logic [AW-1:0] lead_addr = '0, trail_addr = '0;
    logic [DW-1:0] lead_data = '0, trail_data = '0;
    logic          lead_ready, trail_ready;
    logic          mem_valid;
    logic          mem_ready = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic          fault;
    logic          fault_clr = 1'b0;

    int checks = 0;
    int errors = 0;
    int rel_cnt = 0;
    bit done = 0;
    logic [AW-1:0] got_addr [64];
    logic [DW-1:0] got_data [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    redundant_store_cmp #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(QD)) uut (
        .clk(clk), .rst(rst),
        .lead_push(lead_push), .lead_kind(lead_kind), .lead_addr(lead_addr),
        .lead_data(lead_data), .lead_ready(lead_ready),
        .trail_push(trail_push), .trail_kind(trail_kind), .trail_addr(trail_addr),
        .trail_data(trail_data), .trail_ready(trail_ready),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data),
        .fault(fault), .fault_clr(fault_clr)
    );

    always @(posedge clk) begin
        if (!rst && mem_valid && mem_ready) begin
            if (rel_cnt < 64) begin
                got_addr[rel_cnt] = mem_addr;
                got_data[rel_cnt] = mem_data;
            end
            rel_cnt = rel_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_lead(input logic k, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        lead_push = 1'b1; lead_kind = k; lead_addr = a; lead_data = d;
        @(negedge clk);
        lead_push = 1'b0;
    endtask

    task automatic push_trail(input logic k, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        trail_push = 1'b1; trail_kind = k; trail_addr = a; trail_data = d;
        @(negedge clk);
        trail_push = 1'b0;
    endtask

    task automatic push_pair(input logic kl, input logic [AW-1:0] al, input logic [DW-1:0] dl,
                             input logic kt, input logic [AW-1:0] at, input logic [DW-1:0] dt);
        @(negedge clk);
        lead_push = 1'b1;  lead_kind = kl;  lead_addr = al;  lead_data = dl;
        trail_push = 1'b1; trail_kind = kt; trail_addr = at; trail_data = dt;
        @(negedge clk);
        lead_push = 1'b0; trail_push = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        wait_cycles(3);
        // R1: state during reset
        check("R1 fault in reset", fault, 0);
        check("R1 mem_valid in reset", mem_valid, 0);
        rst = 1'b0;
        wait_cycles(1);
        check("R1 lead_ready", lead_ready, 1);
        check("R1 trail_ready", trail_ready, 1);
        check("R1 fault after reset", fault, 0);

        // R2 / R10: trailing thread lags by eight entries
        for (int i = 0; i < 8; i++) push_lead(1'b0, AW'(i*16 + 4), DW'(i*i + 3));
        // R11: leading entries alone release nothing
        check("R11 lone heads", mem_valid, 0);
        for (int i = 0; i < 8; i++) push_trail(1'b0, AW'(i*16 + 4), DW'(i*i + 3));
        wait_cycles(2);
        check("R2 release count", rel_cnt, 8);
        for (int i = 0; i < 8; i++) begin
            check("R10 order addr", got_addr[i], AW'(i*16 + 4));
            check("R10 order data", got_data[i], DW'(i*i + 3));
        end

        // R3: stall on mem_ready low
        mem_ready = 1'b0;
        push_pair(1'b0, 'h200, 'hBEEF, 1'b0, 'h200, 'hBEEF);
        check("R3 offered", mem_valid, 1);
        check("R2 offered addr", mem_addr, 'h200);
        wait_cycles(3);
        check("R3 held valid", mem_valid, 1);
        check("R3 held addr", mem_addr, 'h200);
        check("R3 held data", mem_data, 'hBEEF);
        check("R3 no early release", rel_cnt, 8);
        mem_ready = 1'b1;
        wait_cycles(1);
        mem_ready = 1'b0;
        check("R3 released once", rel_cnt, 9);
        check("R3 gone after handshake", mem_valid, 0);
        mem_ready = 1'b1;
        wait_cycles(2);
        check("R3 no second release", rel_cnt, 9);

        // R4: uncached load pair, data differs and is ignored
        push_pair(1'b1, 'h300, 'h1, 1'b1, 'h300, 'h2);
        wait_cycles(2);
        check("R4 no fault", fault, 0);
        check("R4 no release", rel_cnt, 9);
        push_pair(1'b0, 'h310, 'h7, 1'b0, 'h310, 'h7);
        wait_cycles(2);
        check("R4 retired, next store out", rel_cnt, 10);
        check("R4 next addr", got_addr[9], 'h310);

        // R5 / R6 / R7 / R8: each mismatch kind, then clear
        for (int m = 0; m < 4; m++) begin
            string tag;
            base = rel_cnt;
            case (m)
                0: begin tag = "R5 addr"; push_pair(1'b0, 'h400, 'h5, 1'b0, 'h404, 'h5); end
                1: begin tag = "R5 data"; push_pair(1'b0, 'h400, 'h5, 1'b0, 'h400, 'h6); end
                2: begin tag = "R7 kind"; push_pair(1'b0, 'h400, 'h5, 1'b1, 'h400, 'h5); end
                default: begin tag = "R6 load"; push_pair(1'b1, 'h400, 'h5, 1'b1, 'h408, 'h5); end
            endcase
            wait_cycles(1);
            check(tag, fault, 1);
            check(tag, rel_cnt, base);
            push_pair(1'b0, AW'('h900 + m), DW'('h55 + m), 1'b0, AW'('h900 + m), DW'('h55 + m));
            wait_cycles(3);
            check("R8 sticky", fault, 1);
            check("R8 blocked", mem_valid, 0);
            check("R8 no release", rel_cnt, base);
            fault_clr = 1'b1;
            wait_cycles(1);
            fault_clr = 1'b0;
            wait_cycles(2);
            check("R8 cleared", fault, 0);
            check("R8 resumed", rel_cnt, base + 1);
            check("R8 resumed addr", got_addr[base], AW'('h900 + m));
        end

        // R9: fill the leading queue, overflow push ignored
        base = rel_cnt;
        for (int i = 0; i < QD; i++) push_lead(1'b0, AW'('hA00 + i), DW'(i));
        check("R9 full", lead_ready, 0);
        check("R11 full lead only", mem_valid, 0);
        push_lead(1'b0, 'hAFF, 'hFF);
        for (int i = 0; i < QD; i++) push_trail(1'b0, AW'('hA00 + i), DW'(i));
        wait_cycles(2);
        check("R9 drained", rel_cnt, base + QD);
        check("R9 space again", lead_ready, 1);
        for (int i = 0; i < QD; i++) check("R10 order full", got_addr[base + i], AW'('hA00 + i));
        push_trail(1'b0, 'hAFF, 'hFF);
        wait_cycles(2);
        check("R9 overflow ignored", mem_valid, 0);
        check("R9 overflow count", rel_cnt, base + QD);
        push_lead(1'b0, 'hAFF, 'hFF);
        wait_cycles(1);
        check("R9 late pair", rel_cnt, base + QD + 1);
        check("R9 fault quiet", fault, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule